// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared PCI interrupt request lines onto sixteen legacy interrupt-controller inputs. Each shared line has an 8-bit steering register. A value from 0 to 15 names the controller input it drives. Any value of 16 or more switches that line off. A controller input goes high when at least one enabled request line steered to it is asserted. Several request lines steered to one input combine as a wired-OR.

Software updates the steering registers through a plain write port. The port has one byte lane and one byte enable per request line, and the current register contents can be read back at all times. The block also answers a routing question for a device: given the device's slot number and its interrupt pin (INTA..INTD as 0..3), it reports which shared line that pin lands on. It then reports whether that line is enabled and which controller input it reaches.

The level state is kept as one bit per (controller input, request line) pair and is rebuilt from the current request levels on every cycle. A change of routing therefore takes effect with the same one-cycle latency as a change of request level.

Top module: `irq_line_router`

## Requirements
- R1: After synchronous reset every steering register reads 0x80, so every request line is disabled, and all `irq_out` bits are 0.
- R2: A write changes only the registers whose byte enable is set. Byte lane p (bits 8p+7..8p) belongs to request line p (0 = A .. 3 = D). `cfg_rd_data` returns the last value written to each register, and it holds steady when no write occurs.
- R3: When a request line whose register holds a value v below 16 is asserted, `irq_out[v]` rises exactly one clock later. It falls one clock after the line is deasserted, provided no other source drives it.
- R4: When two or more enabled request lines are steered to the same input, that input stays high while any one of them is asserted, and it falls only after all of them are low.
- R5: A request line whose register holds 16 or more drives no output. Toggling its level leaves `irq_out` unchanged. 16 is the first disabled value and 15 the last enabled one.
- R6: A register write that re-steers an asserted request line moves its level in the clock after the write. The old input drops if nothing else drives it, and the new input rises. The same write timing applies to enabling and disabling the line.
- R7: `pin_pirq` equals (dev_intx + dev_slot - 1) mod 4, where dev_intx 0..3 means INTA..INTD.
- R8: `pin_route_en` is 1 exactly when the register of the line named by `pin_pirq` is below 16. In that case `pin_route_irq` equals that register value. Otherwise `pin_route_irq` is all ones, the encoding used for "no input". `route_en[p]` reports the same enable condition for line p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pirq_lvl | input | NUM_PIRQ | Level of each shared request line, bit p = line p |
| cfg_wr_en | input | 1 | Write strobe for the steering registers |
| cfg_wr_be | input | NUM_PIRQ | Byte enable, bit p selects register p |
| cfg_wr_data | input | 8*NUM_PIRQ | Write data, byte lane p for register p |
| cfg_rd_data | output | 8*NUM_PIRQ | Current steering register contents, byte lane p = register p |
| route_en | output | NUM_PIRQ | Bit p set when register p is below NUM_IRQ |
| irq_out | output | NUM_IRQ | Registered controller input levels |
| dev_slot | input | SLOT_W | Device slot number of the queried pin |
| dev_intx | input | 2 | Queried device pin, 0..3 = INTA..INTD |
| pin_pirq | output | log2(NUM_PIRQ) | Shared line the queried pin maps to |
| pin_route_en | output | 1 | That shared line is enabled |
| pin_route_irq | output | log2(NUM_IRQ) | Controller input it reaches, all ones when disabled |

## Verification
The bench builds the router with its default parameters: four request lines, sixteen controller inputs and a 5-bit slot number. With these values every register byte value from 0 up to and past the enable limit of 16 can be written, including both edge values, 15 and 16. All 32 slots combined with all four pins can be swept exhaustively, so the wrap of the slot-minus-one term for slot 0 is covered. Wired-OR sharing, re-steering of an asserted line and toggling of disabled lines are each driven directly and checked at the output, on the cycle the one-clock latency predicts.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] route_t;
  // Any value of 16 or more disables a line; 0x80 is the reset choice.
  localparam route_t ROUTE_RESET = 8'h80;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [NUM_PIRQ-1:0]        wr_be,
  input  logic [NUM_PIRQ*BYTE_W-1:0] wr_data,
  output route_t [NUM_PIRQ-1:0]      route_q,
  output route_t [NUM_PIRQ-1:0]      route_nxt
);
  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_reg
    // Write-merged next value, also used by the level matrix so that a
    // re-steer costs no extra cycle.
    always_comb begin
      route_nxt[p] = (wr_en && wr_be[p]) ? wr_data[p*BYTE_W +: BYTE_W] : route_q[p];
    end

    always_ff @(posedge clk) begin
      if (rst) route_q[p] <= ROUTE_RESET;
      else     route_q[p] <= route_nxt[p];
    end
  end
endmodule

// File: rtl/irq_level_matrix.sv
module irq_level_matrix
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_IRQ  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PIRQ-1:0]   pirq_lvl,
  input  route_t [NUM_PIRQ-1:0] route_nxt,
  output logic [NUM_IRQ-1:0]    irq_out
);
  localparam int VEC_W = NUM_PIRQ * NUM_IRQ;

  logic [VEC_W-1:0] lvl_d;
  logic [VEC_W-1:0] lvl_q;

  // One bit per (line, request) pair, index line*NUM_PIRQ + request.
  // A register value outside 0..NUM_IRQ-1 matches no line, which is how
  // a disabled request drops out.
  for (genvar l = 0; l < NUM_IRQ; l++) begin : g_line
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_src
      assign lvl_d[l*NUM_PIRQ + p] = pirq_lvl[p] && (route_nxt[p] == BYTE_W'(l));
    end
    assign irq_out[l] = |lvl_q[l*NUM_PIRQ +: NUM_PIRQ];
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_d;
  end
endmodule

// File: rtl/irq_pin_swizzle.sv
module irq_pin_swizzle
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_IRQ  = 16,
  parameter int SLOT_W   = 5,
  localparam int PIRQ_W  = $clog2(NUM_PIRQ),
  localparam int IRQ_W   = $clog2(NUM_IRQ)
) (
  input  logic [SLOT_W-1:0]     slot,
  input  logic [1:0]            intx,
  input  route_t [NUM_PIRQ-1:0] route_q,
  output logic [PIRQ_W-1:0]     pirq,
  output logic                  en,
  output logic [IRQ_W-1:0]      irq
);
  localparam route_t IRQ_LIMIT = BYTE_W'(NUM_IRQ);

  route_t sel;

  always_comb begin
    // Truncation to PIRQ_W bits performs the modulo.
    pirq = PIRQ_W'(intx) + slot[PIRQ_W-1:0] - PIRQ_W'(1);
    sel  = route_q[pirq];
    en   = sel < IRQ_LIMIT;
    irq  = en ? sel[IRQ_W-1:0] : '1;
  end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_IRQ  = 16,
  parameter int SLOT_W   = 5,
  localparam int PIRQ_W  = $clog2(NUM_PIRQ),
  localparam int IRQ_W   = $clog2(NUM_IRQ)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PIRQ-1:0]        pirq_lvl,
  input  logic                       cfg_wr_en,
  input  logic [NUM_PIRQ-1:0]        cfg_wr_be,
  input  logic [NUM_PIRQ*BYTE_W-1:0] cfg_wr_data,
  output logic [NUM_PIRQ*BYTE_W-1:0] cfg_rd_data,
  output logic [NUM_PIRQ-1:0]        route_en,
  output logic [NUM_IRQ-1:0]         irq_out,
  input  logic [SLOT_W-1:0]          dev_slot,
  input  logic [1:0]                 dev_intx,
  output logic [PIRQ_W-1:0]          pin_pirq,
  output logic                       pin_route_en,
  output logic [IRQ_W-1:0]           pin_route_irq
);
  localparam route_t IRQ_LIMIT = BYTE_W'(NUM_IRQ);

  route_t [NUM_PIRQ-1:0] route_q;
  route_t [NUM_PIRQ-1:0] route_nxt;

  irq_route_regs #(.NUM_PIRQ(NUM_PIRQ)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr_en),
    .wr_be     (cfg_wr_be),
    .wr_data   (cfg_wr_data),
    .route_q   (route_q),
    .route_nxt (route_nxt)
  );

  irq_level_matrix #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)) matrix_i (
    .clk       (clk),
    .rst       (rst),
    .pirq_lvl  (pirq_lvl),
    .route_nxt (route_nxt),
    .irq_out   (irq_out)
  );

  irq_pin_swizzle #(.NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ), .SLOT_W(SLOT_W)) swz_i (
    .slot    (dev_slot),
    .intx    (dev_intx),
    .route_q (route_q),
    .pirq    (pin_pirq),
    .en      (pin_route_en),
    .irq     (pin_route_irq)
  );

  assign cfg_rd_data = route_q;

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_en
    assign route_en[p] = route_q[p] < IRQ_LIMIT;
  end
endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk #(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_IRQ  = 16,
  parameter int SLOT_W   = 5,
  localparam int PIRQ_W  = $clog2(NUM_PIRQ),
  localparam int IRQ_W   = $clog2(NUM_IRQ)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_PIRQ-1:0]   pirq_lvl,
  input logic                  cfg_wr_en,
  input logic [NUM_PIRQ*8-1:0] cfg_rd_data,
  input logic [NUM_IRQ-1:0]    irq_out,
  input logic [SLOT_W-1:0]     dev_slot,
  input logic [1:0]            dev_intx,
  input logic [PIRQ_W-1:0]     pin_pirq,
  input logic                  pin_route_en,
  input logic [IRQ_W-1:0]      pin_route_irq
);
  logic [NUM_IRQ-1:0] exp_d, exp_q;
  logic               cmp_q, live_q;

  // Port-level expectation built from the visible registers and levels.
  always_comb begin
    exp_d = '0;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      if (pirq_lvl[p] && (int'(cfg_rd_data[p*8 +: 8]) < NUM_IRQ))
        exp_d[cfg_rd_data[p*8 +: IRQ_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    exp_q  <= exp_d;
    cmp_q  <= !rst && !cfg_wr_en;
    live_q <= !rst;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_rd_data == {NUM_PIRQ{8'h80}}) && (irq_out == '0));

  a_r2_regs_hold: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(cfg_wr_en)) |-> $stable(cfg_rd_data));

  // Covers R3, R4 and R5: outputs follow the wired-OR of enabled lines.
  a_r3_line_levels: assert property (@(posedge clk) disable iff (rst)
    cmp_q |-> (irq_out == exp_q));

  a_r7_slot_swizzle: assert property (@(posedge clk) disable iff (rst)
    pin_pirq == PIRQ_W'(PIRQ_W'(dev_intx) + dev_slot[PIRQ_W-1:0] + PIRQ_W'(NUM_PIRQ-1)));

  a_r8_pin_disabled: assert property (@(posedge clk) disable iff (rst)
    !pin_route_en |-> (pin_route_irq == '1));

  a_r8_pin_enabled: assert property (@(posedge clk) disable iff (rst)
    pin_route_en |-> (cfg_rd_data[pin_pirq*8 +: 8] == 8'(pin_route_irq)));
endmodule

bind irq_line_router irq_line_router_chk #(
  .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ), .SLOT_W(SLOT_W)
) chk_i (.*);

// File: tb/irq_line_router_tb_top.sv
module irq_line_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pirq_lvl = '0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_be = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic [3:0]  route_en;
  logic [15:0] irq_out;
  logic [4:0]  dev_slot = '0;
  logic [1:0]  dev_intx = '0;
  logic [1:0]  pin_pirq;
  logic        pin_route_en;
  logic [3:0]  pin_route_irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_line_router dut_i (
    .clk(clk), .rst(rst), .pirq_lvl(pirq_lvl),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .route_en(route_en), .irq_out(irq_out),
    .dev_slot(dev_slot), .dev_intx(dev_intx), .pin_pirq(pin_pirq),
    .pin_route_en(pin_route_en), .pin_route_irq(pin_route_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] data);
    cfg_wr_en = 1'b1; cfg_wr_be = be; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_be = '0;
  endtask

  task automatic drive(input logic [3:0] lv);
    pirq_lvl = lv;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 regs", cfg_rd_data, 32'h8080_8080);
    check("R1 irq", 32'(irq_out), 32'h0);
    check("R8 route_en", 32'(route_en), 32'h0);
  endtask

  task automatic t_byte_enable;
    wr(4'b0001, 32'h1122_3305);
    check("R2 one lane", cfg_rd_data, 32'h8080_8005);
    wr(4'b1010, 32'h0A0B_0C0D);
    check("R2 two lanes", cfg_rd_data, 32'h0A80_0C05);
    @(negedge clk);
    check("R2 hold", cfg_rd_data, 32'h0A80_0C05);
    check("R8 route_en", 32'(route_en), 32'b1011);
  endtask

  task automatic t_single;
    wr(4'b1111, 32'h8080_8009);
    pirq_lvl = 4'b0001;
    #1;
    check("R3 not before edge", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R3 rise", 32'(irq_out), 32'h0000_0200);
    drive(4'b0000);
    check("R3 fall", 32'(irq_out), 32'h0);
  endtask

  task automatic t_wired_or;
    wr(4'b1111, 32'h8005_0580);
    drive(4'b0110);
    check("R4 both", 32'(irq_out), 32'h0000_0020);
    drive(4'b0100);
    check("R4 one left", 32'(irq_out), 32'h0000_0020);
    drive(4'b0000);
    check("R4 none", 32'(irq_out), 32'h0);
  endtask

  task automatic t_disabled;
    wr(4'b1111, 32'h1080_8003);
    drive(4'b1000);
    check("R5 value 16", 32'(irq_out), 32'h0);
    drive(4'b1001);
    check("R5 other line", 32'(irq_out), 32'h0000_0008);
    drive(4'b0001);
    check("R5 toggle low", 32'(irq_out), 32'h0000_0008);
    drive(4'b1001);
    check("R5 toggle high", 32'(irq_out), 32'h0000_0008);
    wr(4'b1000, 32'hFF00_0000);
    check("R5 value 255", 32'(irq_out), 32'h0000_0008);
    wr(4'b1000, 32'h0F00_0000);
    check("R5 value 15", 32'(irq_out), 32'h0000_8008);
    drive(4'b0000);
  endtask

  task automatic t_reroute;
    wr(4'b1111, 32'h8080_8009);
    drive(4'b0001);
    check("R6 start", 32'(irq_out), 32'h0000_0200);
    wr(4'b0001, 32'h0000_0002);
    check("R6 moved", 32'(irq_out), 32'h0000_0004);
    wr(4'b0001, 32'h0000_0080);
    check("R6 disabled", 32'(irq_out), 32'h0);
    wr(4'b0001, 32'h0000_0000);
    check("R6 line 0", 32'(irq_out), 32'h0000_0001);
    drive(4'b0000);
  endtask

  task automatic t_swizzle;
    for (int s = 0; s < 32; s++) begin
      for (int i = 0; i < 4; i++) begin
        dev_slot = s[4:0]; dev_intx = i[1:0];
        @(negedge clk);
        check("R7 swizzle", 32'(pin_pirq), 32'((i + s + 3) % 4));
      end
    end
  endtask

  task automatic t_pin_status;
    wr(4'b1111, 32'h800C_2007);
    dev_slot = 5'd1;
    for (int i = 0; i < 4; i++) begin
      int r;
      dev_intx = i[1:0];
      @(negedge clk);
      r = int'(cfg_wr_data[i*8 +: 8]);
      check("R8 en", 32'(pin_route_en), (r < 16) ? 32'd1 : 32'd0);
      check("R8 irq", 32'(pin_route_irq), (r < 16) ? 32'(r) : 32'hF);
    end
    check("R8 route_en", 32'(route_en), 32'b0101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_enable();
    t_single();
    t_wired_or();
    t_disabled();
    t_reroute();
    t_swizzle();
    t_pin_status();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule